// File: doc/BRIEF.md
# Decode Group Former

This block sits after instruction-length marking and before rename. It receives a stream of instruction descriptors, one per handshake. Each descriptor gives the uop count of one instruction and says whether the instruction is a compare and whether it is a conditional branch. Descriptors are queued internally. Each cycle the block packs the oldest ones into a decode group of at most four slots and emits that group as one registered output beat.

The slots are not alike. Slot 0 accepts an instruction of up to four uops. Slots 1 to 3 accept only single-uop instructions. A single-uop compare directly followed by a single-uop conditional branch can merge into one fused slot. Only one such merge is allowed per group. Each output beat carries per-slot records, holding a valid bit, the sequence tag of the slot's first instruction, a uop count and a fused bit. It also carries the count of instructions consumed and the count of fused-domain uops produced, so throughput can be measured directly.

A group is formed once five descriptors are queued, or earlier when the producer stops presenting input. This keeps groups full during bursts.

Top module: `decode_group_former`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The slots used in a beat are always contiguous from slot 0, and a group holds at most four slots. Six plain single-uop instructions give a first group of four slots, four instructions and four uops.
- R3: An instruction with more than one uop (in_uops_m1 != 0) is placed only in slot 0. If one reaches a later position, the group closes before it, and it leads the next group.
- R4: Slot 0 may carry up to four uops. A 4-uop instruction followed by three single-uop instructions gives a beat with 4 instructions and 7 uops.
- R5: A single-uop compare (in_is_cmp=1) immediately followed by a single-uop conditional branch (in_is_jcc=1) occupies one slot. That slot has its fused bit set, a uop count of 1, and the compare's tag. A compare not immediately followed by a branch does not fuse.
- R6: At most one slot per beat is fused. A second compare/branch pair in the same group is emitted as two unfused slots.
- R7: out_ninst equals the number of valid slots plus the number of fused slots, so a group can consume five instructions while producing four fused-domain uops. out_nuops is the sum of the slot uop counts.
- R8: A compare that is the last queued descriptor when input goes idle is emitted unfused. A branch arriving later starts a new group.
- R9: While out_valid is 1 and out_ready is 0, every output stays unchanged and no descriptor is consumed.
- R10: No group forms while fewer than five descriptors are queued and in_valid is 1. in_ready falls to 0 when the 16-entry queue is full.
- R11: Each accepted descriptor receives a sequence tag. Tags count up by one per accepted descriptor and start at 0 after reset. A slot's tag equals the previous slot's tag plus one, or plus two if the previous slot is fused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Queue has room |
| in_uops_m1 | input | 2 | Uop count of the instruction minus one |
| in_is_cmp | input | 1 | Instruction is a compare |
| in_is_jcc | input | 1 | Instruction is a conditional branch |
| out_valid | output | 1 | Group beat present |
| out_ready | input | 1 | Downstream accepts the beat |
| out_slot_valid | output | 4 | Per-slot valid, bit s for slot s |
| out_slot_tag | output | 32 | Per-slot tag, slot s in bits [8s+7:8s] |
| out_slot_uops | output | 12 | Per-slot uop count (1..4), slot s in bits [3s+2:3s] |
| out_slot_fused | output | 4 | Per-slot fused flag |
| out_ninst | output | 3 | Instructions consumed by the beat |
| out_nuops | output | 3 | Fused-domain uops in the beat |

## Verification
The assertions do not assume any encoding on the descriptor inputs. A descriptor may carry both flags, or a multi-uop compare, and the slot rules must still hold for it. They do assume that out_ready may fall in any cycle, and they check that a held beat does not change. Which instructions land in a group depends on when the producer pauses. The stimulus therefore presents each test sequence back to back with out_ready low and then drops in_valid. This fixes the first group by the first five descriptors, or by all of them for shorter sequences. The queue is drained completely between sequences.

// File: rtl/gf_pkg.sv
package gf_pkg;

  // architectural constants of the decoder front
  localparam int NSLOT    = 4;  // decoder slots per group
  localparam int WIN      = 5;  // descriptors visible to the packer (4 slots + 1 fused)
  localparam int DESC_W   = 4;  // packed descriptor width
  localparam int UOP_W    = 3;  // per-slot uop count width (1..4)
  localparam int CNT_W    = $clog2(WIN + 1); // per-beat instruction / uop count width

  typedef struct packed {
    logic       is_cmp;
    logic       is_jcc;
    logic [1:0] uop_m1;
  } gf_desc_t;

  function automatic logic can_lead_fusion(gf_desc_t d);
    return d.is_cmp && (d.uop_m1 == 2'd0);
  endfunction

  function automatic logic can_end_fusion(gf_desc_t d);
    return d.is_jcc && (d.uop_m1 == 2'd0);
  endfunction

endpackage

// File: rtl/gf_window_fifo.sv
module gf_window_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 16,   // power of two
  parameter int WIN   = 5,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int PW    = $clog2(WIN + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    push,
  input  logic [W-1:0]            push_data,
  input  logic [PW-1:0]           pop_n,
  output logic [WIN-1:0][W-1:0]   win_data,
  output logic [CW-1:0]           count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  // storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr + AW'(pop_n);
      count  <= count + CW'(push) - CW'(pop_n);
    end
  end

  // multi-entry read window starting at the oldest entry
  for (genvar k = 0; k < WIN; k++) begin : g_win
    assign win_data[k] = mem[rd_ptr + AW'(k)];
  end

  // R10: the packer never pops more than is queued
  p_pop_bound_r10: assert property (@(posedge clk) disable iff (rst)
    CW'(pop_n) <= count);

  // R10: the producer side never writes into a full queue
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CW'(DEPTH)));

endmodule

// File: rtl/gf_group_packer.sv
module gf_group_packer
  import gf_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int EW    = TAG_W + DESC_W
) (
  input  logic [WIN-1:0][EW-1:0]     win,
  input  logic [CNT_W-1:0]           navail,
  output logic [NSLOT-1:0]           slot_valid,
  output logic [NSLOT-1:0][TAG_W-1:0] slot_tag,
  output logic [NSLOT-1:0][UOP_W-1:0] slot_uops,
  output logic [NSLOT-1:0]           slot_fused,
  output logic [CNT_W-1:0]           ninst,
  output logic [CNT_W-1:0]           nuops
);

  // one zero entry past the window keeps every lookahead index in range
  logic [WIN:0][EW-1:0] wpad;
  assign wpad = {{EW{1'b0}}, win};

  always_comb begin
    int       p;
    int       pi;
    int       pn;
    int       tot;
    logic     closed;
    logic     fuse_used;
    gf_desc_t cur;
    gf_desc_t nxt;

    slot_valid = '0;
    slot_tag   = '0;
    slot_uops  = '0;
    slot_fused = '0;
    p          = 0;
    tot        = 0;
    closed     = 1'b0;
    fuse_used  = 1'b0;

    for (int s = 0; s < NSLOT; s++) begin
      pi  = (p < WIN) ? p : WIN;
      pn  = (p + 1 < WIN) ? p + 1 : WIN;
      cur = gf_desc_t'(wpad[pi][DESC_W-1:0]);
      nxt = gf_desc_t'(wpad[pn][DESC_W-1:0]);
      if (!closed && (p < int'(navail))) begin
        if ((s != 0) && (cur.uop_m1 != 2'd0)) begin
          // multi-uop instruction outside slot 0: close the group here
          closed = 1'b1;
        end else begin
          slot_valid[s] = 1'b1;
          slot_tag[s]   = wpad[pi][EW-1:DESC_W];
          if (!fuse_used && can_lead_fusion(cur) &&
              (p + 1 < int'(navail)) && can_end_fusion(nxt)) begin
            slot_fused[s] = 1'b1;
            slot_uops[s]  = UOP_W'(1);
            fuse_used     = 1'b1;
            p             = p + 2;
          end else begin
            slot_uops[s]  = UOP_W'(cur.uop_m1) + UOP_W'(1);
            p             = p + 1;
          end
          tot = tot + int'(slot_uops[s]);
        end
      end else begin
        closed = 1'b1;
      end
    end

    ninst = CNT_W'(p);
    nuops = CNT_W'(tot);
  end

endmodule

// File: rtl/gf_out_stage.sv
module gf_out_stage
  import gf_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic                        out_ready,
  input  logic [NSLOT-1:0]            g_valid,
  input  logic [NSLOT-1:0][TAG_W-1:0] g_tag,
  input  logic [NSLOT-1:0][UOP_W-1:0] g_uops,
  input  logic [NSLOT-1:0]            g_fused,
  input  logic [CNT_W-1:0]            g_ninst,
  input  logic [CNT_W-1:0]            g_nuops,
  output logic                        out_valid,
  output logic [NSLOT-1:0]            o_valid,
  output logic [NSLOT-1:0][TAG_W-1:0] o_tag,
  output logic [NSLOT-1:0][UOP_W-1:0] o_uops,
  output logic [NSLOT-1:0]            o_fused,
  output logic [CNT_W-1:0]            o_ninst,
  output logic [CNT_W-1:0]            o_nuops
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      o_valid   <= '0;
      o_tag     <= '0;
      o_uops    <= '0;
      o_fused   <= '0;
      o_ninst   <= '0;
      o_nuops   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      o_valid   <= g_valid;
      o_tag     <= g_tag;
      o_uops    <= g_uops;
      o_fused   <= g_fused;
      o_ninst   <= g_ninst;
      o_nuops   <= g_nuops;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9: a stalled beat is held intact
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(o_valid) && $stable(o_tag) &&
      $stable(o_uops) && $stable(o_fused) && $stable(o_ninst) && $stable(o_nuops)));

  // R2: slots fill from slot 0 without gaps
  p_contig_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (o_valid == 4'b0001 || o_valid == 4'b0011 ||
                   o_valid == 4'b0111 || o_valid == 4'b1111));

  // R3: only slot 0 carries more than one uop
  p_multi_first_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((!o_valid[1] || o_uops[1] == 3'd1) &&
                   (!o_valid[2] || o_uops[2] == 3'd1) &&
                   (!o_valid[3] || o_uops[3] == 3'd1)));

  // R4: slot 0 uop count stays within 1..4
  p_slot0_range_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (o_uops[0] >= 3'd1 && o_uops[0] <= 3'd4));

  // R5: a fused slot is a valid single-uop slot
  p_fused_shape_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((o_fused & ~o_valid) == '0) &&
                  (!o_fused[0] || o_uops[0] == 3'd1));

  // R6: at most one fusion per beat
  p_one_fuse_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(o_fused) <= 1));

  // R7: consumed instructions match slots plus fusions
  p_counts_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(o_ninst) == $countones(o_valid) + $countones(o_fused)) &&
                  (o_ninst <= 3'd5) && (o_nuops <= 3'd7));

  // R11: slot tags advance by one instruction, or two after a fused slot
  p_tag_seq_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && o_valid[1]) |->
      (o_tag[1] == o_tag[0] + TAG_W'(1) + TAG_W'(o_fused[0])));

endmodule

// File: rtl/decode_group_former.sv
module decode_group_former
  import gf_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [1:0]               in_uops_m1,
  input  logic                     in_is_cmp,
  input  logic                     in_is_jcc,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NSLOT-1:0]         out_slot_valid,
  output logic [NSLOT*TAG_W-1:0]   out_slot_tag,
  output logic [NSLOT*UOP_W-1:0]   out_slot_uops,
  output logic [NSLOT-1:0]         out_slot_fused,
  output logic [CNT_W-1:0]         out_ninst,
  output logic [CNT_W-1:0]         out_nuops
);

  localparam int EW = TAG_W + DESC_W;
  localparam int CW = $clog2(DEPTH + 1);

  logic [TAG_W-1:0]          tag_q;
  logic                      push;
  gf_desc_t                  in_desc;
  logic [WIN-1:0][EW-1:0]    win;
  logic [CW-1:0]             fifo_count;
  logic [CNT_W-1:0]          navail;
  logic [CNT_W-1:0]          pop_n;
  logic                      form;
  logic                      load;

  logic [NSLOT-1:0]            g_valid;
  logic [NSLOT-1:0][TAG_W-1:0] g_tag;
  logic [NSLOT-1:0][UOP_W-1:0] g_uops;
  logic [NSLOT-1:0]            g_fused;
  logic [CNT_W-1:0]            g_ninst;
  logic [CNT_W-1:0]            g_nuops;

  logic [NSLOT-1:0][TAG_W-1:0] o_tag;
  logic [NSLOT-1:0][UOP_W-1:0] o_uops;

  assign in_desc  = '{is_cmp: in_is_cmp, is_jcc: in_is_jcc, uop_m1: in_uops_m1};
  assign in_ready = (fifo_count < CW'(DEPTH));
  assign push     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)       tag_q <= '0;
    else if (push) tag_q <= tag_q + TAG_W'(1);
  end

  gf_window_fifo #(.W(EW), .DEPTH(DEPTH), .WIN(WIN)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data ({tag_q, in_desc}),
    .pop_n     (pop_n),
    .win_data  (win),
    .count     (fifo_count)
  );

  // form a group once the window is full or the producer pauses
  assign navail = (fifo_count >= CW'(WIN)) ? CNT_W'(WIN) : CNT_W'(fifo_count);
  assign form   = (fifo_count != '0) && ((fifo_count >= CW'(WIN)) || !in_valid);
  assign load   = form && (!out_valid || out_ready);
  assign pop_n  = load ? g_ninst : '0;

  gf_group_packer #(.TAG_W(TAG_W)) u_packer (
    .win        (win),
    .navail     (navail),
    .slot_valid (g_valid),
    .slot_tag   (g_tag),
    .slot_uops  (g_uops),
    .slot_fused (g_fused),
    .ninst      (g_ninst),
    .nuops      (g_nuops)
  );

  gf_out_stage #(.TAG_W(TAG_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .out_ready (out_ready),
    .g_valid   (g_valid),
    .g_tag     (g_tag),
    .g_uops    (g_uops),
    .g_fused   (g_fused),
    .g_ninst   (g_ninst),
    .g_nuops   (g_nuops),
    .out_valid (out_valid),
    .o_valid   (out_slot_valid),
    .o_tag     (o_tag),
    .o_uops    (o_uops),
    .o_fused   (out_slot_fused),
    .o_ninst   (out_ninst),
    .o_nuops   (out_nuops)
  );

  assign out_slot_tag  = o_tag;
  assign out_slot_uops = o_uops;

  // R10: nothing is handed downstream while a burst is still filling the window
  p_wait_fill_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fifo_count < CW'(WIN) && !out_valid) |=> !out_valid);

endmodule

// File: tb/tb_decode_group_former.sv
`timescale 1ns/1ps
module tb_decode_group_former;

  localparam int TAG_W = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_uops_m1;
  logic        in_is_cmp;
  logic        in_is_jcc;
  logic        out_valid;
  logic        out_ready;
  logic [3:0]  out_slot_valid;
  logic [31:0] out_slot_tag;
  logic [11:0] out_slot_uops;
  logic [3:0]  out_slot_fused;
  logic [2:0]  out_ninst;
  logic [2:0]  out_nuops;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [7:0] base = 8'd0;

  always #10 clk = ~clk;  // 50 MHz

  decode_group_former #(.TAG_W(TAG_W), .DEPTH(16)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_uops_m1(in_uops_m1), .in_is_cmp(in_is_cmp), .in_is_jcc(in_is_jcc),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_slot_valid(out_slot_valid), .out_slot_tag(out_slot_tag),
    .out_slot_uops(out_slot_uops), .out_slot_fused(out_slot_fused),
    .out_ninst(out_ninst), .out_nuops(out_nuops)
  );

  // descriptor nibble: bit3 compare, bit2 branch, bits1:0 uops-1
  // vector: {len[3:0], seq[31:0] (entry k at nibble k), ninst[2:0], nuops[2:0], slots[3:0], fused[3:0]}
  localparam int NV = 12;
  localparam logic [49:0] VEC [NV] = '{
    {4'd6, 32'h00000000, 3'd4, 3'd4, 4'hF, 4'h0},  // R2  six plain
    {4'd4, 32'h00000030, 3'd1, 3'd1, 4'h1, 4'h0},  // R3  S M4 S S
    {4'd5, 32'h00000003, 3'd4, 3'd7, 4'hF, 4'h0},  // R4  M4 S S S S
    {4'd6, 32'h00000480, 3'd5, 3'd4, 4'hF, 4'h2},  // R5 R7  S C J S S S
    {4'd5, 32'h00004848, 3'd5, 3'd4, 4'hF, 4'h1},  // R6  C J C J S
    {4'd5, 32'h00000482, 3'd5, 3'd6, 4'hF, 4'h2},  // R7  M3 C J S S
    {4'd5, 32'h00048000, 3'd5, 3'd4, 4'hF, 4'h8},  // R5  S S S C J
    {4'd3, 32'h00000011, 3'd1, 3'd2, 4'h1, 4'h0},  // R3  M2 M2 S
    {4'd2, 32'h00000048, 3'd2, 3'd1, 4'h1, 4'h1},  // R5  C J alone
    {4'd5, 32'h00000408, 3'd4, 3'd4, 4'hF, 4'h0},  // R5  C S J S S no fusion
    {4'd5, 32'h00000483, 3'd5, 3'd7, 4'hF, 4'h2},  // R4 R7  M4 C J S S
    {4'd3, 32'h00000800, 3'd3, 3'd3, 4'h7, 4'h0}   // R8  S S C then idle
  };
  string vreq [NV] = '{"R2", "R3", "R4", "R5/R7", "R6", "R7", "R5",
                       "R3", "R5", "R5", "R4/R7", "R8"};

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic push(logic [3:0] d);
    in_valid   = 1'b1;
    in_is_cmp  = d[3];
    in_is_jcc  = d[2];
    in_uops_m1 = d[1:0];
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain(int n);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    repeat (n) @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [3:0]  sv;
    logic [2:0]  sn;
    logic [31:0] stag;
    int          acc;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    in_uops_m1 = 2'd0; in_is_cmp = 1'b0; in_is_jcc = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    chk("R1", "in_ready",  32'(in_ready),  32'd1);

    // table walk: first group of each sequence
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < int'(VEC[v][49:46]); k++) push(VEC[v][14 + 4*k +: 4]);
      idle();
      chk(vreq[v], "out_valid", 32'(out_valid),      32'd1);
      chk(vreq[v], "ninst",     32'(out_ninst),      32'(VEC[v][13:11]));
      chk(vreq[v], "nuops",     32'(out_nuops),      32'(VEC[v][10:8]));
      chk(vreq[v], "slots",     32'(out_slot_valid), 32'(VEC[v][7:4]));
      chk(vreq[v], "fused",     32'(out_slot_fused), 32'(VEC[v][3:0]));
      chk("R11", "slot0 tag",   32'(out_slot_tag[7:0]), 32'(base));
      if (v == 0) begin
        // R9: held beat stays intact, then the next beat starts at the right tag
        sv = out_slot_valid; sn = out_ninst; stag = out_slot_tag;
        repeat (3) @(negedge clk);
        chk("R9", "held slots", 32'(out_slot_valid), 32'(sv));
        chk("R9", "held ninst", 32'(out_ninst), 32'(sn));
        chk("R9", "held tags",  out_slot_tag, stag);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R9", "next ninst", 32'(out_ninst), 32'd2);
        chk("R9", "next tag",   32'(out_slot_tag[7:0]), 32'(base + 8'd4));
      end
      if (v == 1) begin
        // R3: the multi-uop instruction leads the next group in slot 0
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R3", "lead uops", 32'(out_slot_uops[2:0]), 32'd4);
        chk("R3", "lead tag",  32'(out_slot_tag[7:0]), 32'(base + 8'd1));
      end
      if (v == 3) begin
        // R11: slot 2 follows the fused slot 1 by two tags
        chk("R11", "slot2 tag", 32'(out_slot_tag[23:16]), 32'(base + 8'd3));
        chk("R5", "fused slot uops", 32'(out_slot_uops[5:3]), 32'd1);
      end
      if (v == 11) begin
        // R8: branch arriving after the idle does not join the compare
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R8", "empty after release", 32'(out_valid), 32'd0);
        push(4'h4);
        idle();
        chk("R8", "branch ninst", 32'(out_ninst), 32'd1);
        chk("R8", "branch fused", 32'(out_slot_fused), 32'd0);
        chk("R8", "branch tag",   32'(out_slot_tag[7:0]), 32'(base + 8'd3));
        base = base + 8'd1;
      end
      base = base + 8'(VEC[v][49:46]);
      drain(30);
    end

    // R10: no group while a burst is still filling, then queue-full backpressure
    for (int k = 0; k < 4; k++) push(4'h0);
    chk("R10", "no early group", 32'(out_valid), 32'd0);
    acc = 4;
    in_valid = 1'b1;
    while (in_ready && acc < 40) begin
      @(negedge clk);
      acc++;
    end
    chk("R10", "accepted before full", 32'(acc), 32'd20);
    chk("R10", "in_ready when full", 32'(in_ready), 32'd0);
    drain(40);
    chk("R10", "queue drained", 32'(out_valid), 32'd0);

    finish_run();
  end

endmodule